// File: doc/BRIEF.md
# Dual-Accumulator Frequency Sweep and Phase Core

This core is the numeric heart of a direct digital synthesizer. A first accumulator produces the current frequency tuning word. Depending on the selected mode, it holds a fixed start frequency, adds a signed step without bound, or ramps between a lower and an upper limit. The ramp may run once or bounce back and forth as a triangle. A second accumulator adds that tuning word every clock to produce a running phase. The top bits of that phase are presented for a downstream phase-to-amplitude stage.

Two clear inputs give software-free control of the sweep. The one-shot clear zeroes only the frequency accumulator for the cycle in which it is sampled. The limits and step are left alone, so repeated pulses yield a sawtooth sweep. The held clear pins both accumulators at zero for as long as it stays high, so the phase restarts from a known origin when it is released. Mode code 0 selects single tone, 1 FSK, 2 ramped FSK, 3 chirp and 4 PSK.

Top module: `dds_sweep_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, the frequency word and the phase register become zero.
- R2: When `hold_clr` is sampled high, both the frequency word and the full phase register are zero after that edge, whatever the mode, `pulse_clr`, `tri_en` or limits.
- R3: When `pulse_clr` is high and `hold_clr` low, the frequency word is zero after the edge, in every mode; the limits and step are inputs and are not altered, and the next cycle resumes from zero.
- R4: In mode 0 (single tone), the frequency word takes the value of `f_lo` after each edge.
- R5: In mode 3 (chirp), the frequency word becomes its previous value plus `f_step` modulo 2^FREQ_W after each edge, with no clamping.
- R6: In mode 2 with `tri_en` high, an internal direction starts upward. Upward, the word advances by `f_step` unless it is at or above `f_hi` or within `f_step` of it, in which case it becomes `f_hi` and the direction turns downward. Downward, it retreats by `f_step` unless it is at or below `f_lo` or within `f_step` of it, in which case it becomes `f_lo` and the direction turns upward. `f_step` is treated as unsigned here.
- R7: In mode 2 with `tri_en` low, the word climbs by the upward rule of R6 and then stays at `f_hi`. The direction is forced upward whenever the block is not in mode 2 with `tri_en` high, and also by reset and `hold_clr`.
- R8: In modes 1, 4 and the unused codes 5 to 7, the frequency word holds its value.
- R9: When `hold_clr` is low, the phase register becomes its previous value plus the previous frequency word, modulo 2^FREQ_W. `phase_out` is its top PHASE_OUT_W bits.
- R10: `tri_en` has no effect on the frequency word in any mode other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 3 | Operating mode code (0..4 used) |
| f_lo | input | FREQ_W | Lower frequency limit / single-tone word |
| f_hi | input | FREQ_W | Upper frequency limit |
| f_step | input | FREQ_W | Frequency step (signed in chirp, magnitude in ramp) |
| tri_en | input | 1 | Triangle sweep enable (mode 2 only) |
| pulse_clr | input | 1 | One-cycle clear of the frequency accumulator |
| hold_clr | input | 1 | Level clear of both accumulators |
| freq_word | output | FREQ_W | Current frequency tuning word |
| phase_out | output | PHASE_OUT_W | Top bits of the phase accumulator |

## Verification
The ramp bound property assumes that `f_lo` does not exceed `f_hi` and that the limits are steady across the checked edge. The stimulus sets each limit pair once, before a run, and always with the lower limit not above the upper one. The checker waits one cycle past reset before comparing against the past, so it relies on reset being held for at least one edge, which the stimulus always does. Clears are injected at random within each mode run, so every mode is exercised both from zero and mid-sweep.

// File: rtl/dds_sweep_pkg.sv
// Shared mode encoding for the sweep core.
package dds_sweep_pkg;
    typedef enum logic [2:0] {
        MODE_TONE  = 3'd0,
        MODE_FSK   = 3'd1,
        MODE_RAMP  = 3'd2,
        MODE_CHIRP = 3'd3,
        MODE_PSK   = 3'd4
    } sweep_mode_e;
endpackage

// File: rtl/dds_freq_acc.sv
// Frequency accumulator (first stage). Produces the tuning word per mode:
// load, hold, free-running add, or clamped ramp with optional triangle.
// Assumes f_lo <= f_hi when ramping; f_step is a magnitude in ramp mode.
module dds_freq_acc
    import dds_sweep_pkg::*;
#(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   mode,
    input  logic [W-1:0] f_lo,
    input  logic [W-1:0] f_hi,
    input  logic [W-1:0] f_step,
    input  logic         tri_en,
    input  logic         pulse_clr,
    input  logic         hold_clr,
    output logic [W-1:0] freq_q
);
    logic         going_down;
    logic         hit_top;
    logic         hit_bottom;
    logic         tri_active;
    logic [W-1:0] ramp_next;
    logic         dir_next;

    // Detect arrival at either limit within one step.
    always_comb begin
        hit_top    = (freq_q >= f_hi) || ((f_hi - freq_q) <= f_step);
        hit_bottom = (freq_q <= f_lo) || ((freq_q - f_lo) <= f_step);
        tri_active = (mode == MODE_RAMP) && tri_en;
    end

    // Choose the next ramp value and direction.
    always_comb begin
        ramp_next = freq_q;
        dir_next  = 1'b0;
        if (going_down && tri_active) begin
            if (hit_bottom) begin
                ramp_next = f_lo;
                dir_next  = 1'b0;
            end else begin
                ramp_next = freq_q - f_step;
                dir_next  = 1'b1;
            end
        end else begin
            if (hit_top) begin
                ramp_next = f_hi;
                dir_next  = tri_active;
            end else begin
                ramp_next = freq_q + f_step;
                dir_next  = 1'b0;
            end
        end
    end

    // Register the tuning word with clear priority over mode updates.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr) begin
            freq_q     <= '0;
            going_down <= 1'b0;
        end else begin
            if (pulse_clr) begin
                freq_q <= '0;
            end else begin
                case (mode)
                    MODE_TONE:  freq_q <= f_lo;
                    MODE_CHIRP: freq_q <= freq_q + f_step;
                    MODE_RAMP:  freq_q <= ramp_next;
                    default:    freq_q <= freq_q;
                endcase
            end
            if (!tri_active)
                going_down <= 1'b0;
            else if (!pulse_clr)
                going_down <= dir_next;
        end
    end
endmodule

// File: rtl/dds_phase_acc.sv
// Phase accumulator (second stage). Adds the tuning word every clock and
// exposes the top bits. Assumes wrap-around modulo 2^W is intended.
module dds_phase_acc #(
    parameter int W  = 48,
    parameter int OW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hold_clr,
    input  logic [W-1:0]  freq,
    output logic [W-1:0]  phase_q,
    output logic [OW-1:0] phase_out
);
    // Integrate the tuning word, held at zero by reset or level clear.
    always_ff @(posedge clk) begin
        if (!rst_n || hold_clr)
            phase_q <= '0;
        else
            phase_q <= phase_q + freq;
    end

    // Truncate to the output width.
    assign phase_out = phase_q[W-1 -: OW];
endmodule

// File: rtl/dds_sweep_core.sv
// Top of the sweep core: frequency stage feeding phase stage.
// Assumes PHASE_OUT_W <= FREQ_W.
module dds_sweep_core #(
    parameter int FREQ_W      = 48,
    parameter int PHASE_OUT_W = 14
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             mode,
    input  logic [FREQ_W-1:0]      f_lo,
    input  logic [FREQ_W-1:0]      f_hi,
    input  logic [FREQ_W-1:0]      f_step,
    input  logic                   tri_en,
    input  logic                   pulse_clr,
    input  logic                   hold_clr,
    output logic [FREQ_W-1:0]      freq_word,
    output logic [PHASE_OUT_W-1:0] phase_out
);
    logic [FREQ_W-1:0] phase_acc_q;

    dds_freq_acc #(.W(FREQ_W)) u_freq (
        .clk(clk), .rst_n(rst_n), .mode(mode), .f_lo(f_lo), .f_hi(f_hi),
        .f_step(f_step), .tri_en(tri_en), .pulse_clr(pulse_clr),
        .hold_clr(hold_clr), .freq_q(freq_word)
    );

    dds_phase_acc #(.W(FREQ_W), .OW(PHASE_OUT_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .hold_clr(hold_clr), .freq(freq_word),
        .phase_q(phase_acc_q), .phase_out(phase_out)
    );
endmodule

// File: rtl/dds_sweep_chk.sv
// Property checker for the sweep core, bound to the top module.
module dds_sweep_chk #(
    parameter int W = 48
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   mode,
    input logic [W-1:0] f_lo,
    input logic [W-1:0] f_hi,
    input logic [W-1:0] f_step,
    input logic         tri_en,
    input logic         pulse_clr,
    input logic         hold_clr,
    input logic [W-1:0] freq_word,
    input logic [W-1:0] phase_acc
);
    logic armed;
    // Allow past-value checks only after one cycle out of reset.
    always_ff @(posedge clk) armed <= rst_n;

    assert_hold_clear_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        hold_clr |=> (freq_word == '0) && (phase_acc == '0));
    assert_pulse_clear_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (pulse_clr && !hold_clr) |=> (freq_word == '0));
    assert_tone_load_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (mode == 3'd0 && !pulse_clr && !hold_clr) |=> (freq_word == $past(f_lo)));
    assert_chirp_add_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (mode == 3'd3 && !pulse_clr && !hold_clr) |=> (freq_word == $past(freq_word) + $past(f_step)));
    assert_ramp_bound_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        (mode == 3'd2 && !pulse_clr && !hold_clr && f_lo <= f_hi && freq_word <= f_hi)
        |=> (freq_word <= $past(f_hi)));
    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        ((mode == 3'd1 || mode >= 3'd4) && !pulse_clr && !hold_clr) |=> $stable(freq_word));
    assert_phase_add_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !hold_clr |=> (phase_acc == $past(phase_acc) + $past(freq_word)));
endmodule

bind dds_sweep_core dds_sweep_chk #(.W(FREQ_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .f_lo(f_lo), .f_hi(f_hi),
    .f_step(f_step), .tri_en(tri_en), .pulse_clr(pulse_clr),
    .hold_clr(hold_clr), .freq_word(freq_word), .phase_acc(phase_acc_q)
);

// File: tb/sim_dds_sweep_core.sv
module sim_dds_sweep_core;
    localparam int W  = 16;
    localparam int OW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    mode = '0;
    logic [W-1:0]  f_lo = '0, f_hi = '0, f_step = '0;
    logic          tri_en = 1'b0, pulse_clr = 1'b0, hold_clr = 1'b0;
    logic [W-1:0]  freq_word;
    logic [OW-1:0] phase_out;

    logic [W-1:0]  ef = '0, ep = '0;
    bit            edn = 1'b0;
    int            n_vec = 0, n_bad = 0;
    logic [W-1:0]  seen_max, seen_min;

    always #5 clk = ~clk;

    dds_sweep_core #(.FREQ_W(W), .PHASE_OUT_W(OW)) u0 (
        .clk(clk), .rst_n(rst_n), .mode(mode), .f_lo(f_lo), .f_hi(f_hi),
        .f_step(f_step), .tri_en(tri_en), .pulse_clr(pulse_clr),
        .hold_clr(hold_clr), .freq_word(freq_word), .phase_out(phase_out)
    );

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Expected next state from the requirements, evaluated with pre-edge inputs.
    task automatic model_edge();
        logic [W-1:0] nf;
        bit tri_on, nd;
        tri_on = (mode == 3'd2) && tri_en;
        nf = ef; nd = 1'b0;
        ep = hold_clr ? '0 : ep + ef;                      // R9
        if (hold_clr) begin nf = '0; nd = 1'b0; end        // R2
        else begin
            if (pulse_clr) nf = '0;                        // R3
            else if (mode == 3'd0) nf = f_lo;              // R4
            else if (mode == 3'd3) nf = ef + f_step;       // R5
            else if (mode == 3'd2) begin                   // R6 / R7
                if (edn && tri_on) begin
                    if (ef <= f_lo || (ef - f_lo) <= f_step) begin nf = f_lo; nd = 1'b0; end
                    else begin nf = ef - f_step; nd = 1'b1; end
                end else begin
                    if (ef >= f_hi || (f_hi - ef) <= f_step) begin nf = f_hi; nd = tri_on; end
                    else begin nf = ef + f_step; nd = 1'b0; end
                end
            end
            if (!tri_on) nd = 1'b0;
            else if (pulse_clr) nd = edn;
        end
        ef = nf; edn = nd;
    endtask

    function automatic string tag_of(input bit hc, input bit pc, input logic [2:0] m, input bit t);
        if (hc) return "R2";
        if (pc) return "R3";
        case (m)
            3'd0: return t ? "R4 R10" : "R4";
            3'd3: return t ? "R5 R10" : "R5";
            3'd2: return t ? "R6" : "R7";
            default: return t ? "R8 R10" : "R8";
        endcase
    endfunction

    task automatic cycle(input bit hc, input bit pc);
        string tg;
        hold_clr = hc; pulse_clr = pc;
        tg = tag_of(hc, pc, mode, tri_en);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check(tg, freq_word, ef);
        check("R9", {8'h00, phase_out}, {8'h00, ep[W-1 -: OW]});
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        finish_run();
    end

    initial begin
        logic [W-1:0] lo_t[4] = '{16'd100, 16'd0,      16'd500, 16'd10};
        logic [W-1:0] hi_t[4] = '{16'd130, 16'hFFFF,   16'd500, 16'd400};
        logic [W-1:0] st_t[4] = '{16'd7,   16'h1234,   16'd3,   16'hFFF9};
        mode = 3'd3; f_step = 16'd5;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", freq_word, '0);
        check("R1", {8'h00, phase_out}, '0);
        rst_n = 1'b1;
        // Sweep every mode, triangle setting and limit set with random clears.
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 8; m++) begin
                for (int t = 0; t < 2; t++) begin
                    f_lo = lo_t[c]; f_hi = hi_t[c]; f_step = st_t[c];
                    mode = 3'(m); tri_en = t[0];
                    cycle(1'b1, 1'b0);
                    cycle(1'b1, 1'b1);
                    for (int k = 0; k < 60; k++)
                        cycle(($urandom % 32) == 0, ($urandom % 16) == 0);
                end
            end
        end
        // Directed: single ramp settles at the upper limit (R7).
        f_lo = 16'd100; f_hi = 16'd130; f_step = 16'd7; mode = 3'd2; tri_en = 1'b0;
        cycle(1'b1, 1'b0);
        for (int k = 0; k < 40; k++) cycle(1'b0, 1'b0);
        check("R7 settle", freq_word, 16'd130);
        // Directed: triangle touches both limits exactly (R6).
        tri_en = 1'b1; seen_max = '0; seen_min = '1;
        for (int k = 0; k < 40; k++) begin
            cycle(1'b0, 1'b0);
            if (freq_word > seen_max) seen_max = freq_word;
            if (freq_word < seen_min && k > 4) seen_min = freq_word;
        end
        check("R6 top", seen_max, 16'd130);
        check("R6 bottom", seen_min, 16'd100);
        // Directed: pulse clear gives a sawtooth that restarts from zero (R3).
        mode = 3'd3; tri_en = 1'b0; f_step = 16'd9;
        cycle(1'b0, 1'b1);
        check("R3 zero", freq_word, '0);
        cycle(1'b0, 1'b0);
        check("R3 resume", freq_word, 16'd9);
        finish_run();
    end
endmodule